// File: doc/BRIEF.md
# AC-link Codec Register Access Engine

This block sits on the host side of an AC-link and gives software a small register window for reading and writing the registers of an attached audio codec. Software places a command in a command address register, plus a value in a command data register when the command is a write. The engine puts the command into the next outgoing 256-bit serial frame: the address image goes in slot 1, and the data image goes in slot 2 when the command is a write. Each half of the command raises its own sticky "sent" flag once its last bit has left the pin. On the receive side, the engine deserialises each incoming frame. It latches any valid status address and status data slots into registers that software reads back, and raises a sticky "ready" flag for each of them. Software compares the returned index with the one it asked for, clears the flags by writing zeros, and retries if the two differ.

The host registers use the raw 20-bit slot images, so no field is repacked. The same register window also drives the link control lines. One control bit holds the codec in cold reset. Another drives the sync line high to wake a sleeping codec while the link is idle. A third starts the frame stream. A read-only bit shows whether the codec marked its last frame as valid. The bit clock comes from the codec. It is oversampled in the system clock domain, so all logic runs on one clock.

Top module: `aclink_cmd_engine`

## Requirements
- R1: After reset, every register reads 0, `sdata_out` and `sync` are low and `codec_rst_n` is high. Registers by index: 0 control, 1 command address / status address, 2 command data / status data, 3 transmit status, 4 receive status, 5 slot enable.
- R2: While control bit 11 is set, `codec_rst_n` is low and the link sends no frames: `sync` and `sdata_out` stay low.
- R3: Control bit 10 drives `sync` high while the link is not running. While frames are running it has no effect on `sync`.
- R4: With control bit 5 set and bit 11 clear, the engine sends 256-bit frames back to back, MSB first, changing output on bit-clock rising edges. `sync` is high for bit positions 0 to 15. Tag bit 15 (frame valid) is always 1.
- R5: A write command uses command address bit 19 = 0, index in bits 18:12, and value in command data bits 19:4. The next frame has tag bits 14 and 13 set, slot 1 (bits 16..35) equal to the address image, and slot 2 (bits 36..55) equal to the data image. All other command-address and command-data bits are sent as 0.
- R6: A read command (bit 19 = 1) sets tag bit 14 only and sends slot 2 as zeros.
- R7: While slot enable bit 0 is clear, a queued command is held and not sent. It goes out in the first frame that starts after the bit is set.
- R8: Transmit status bit 31 sets after the last slot 1 bit of a command frame. Bit 30 sets after the last slot 2 bit of a write frame. Both are sticky: writing 0 to a bit clears it, and writing 1 leaves it unchanged.
- R9: Input is sampled on bit-clock falling edges. When an incoming tag has bit 14 set, slot 1 is latched (read at index 1) and receive status bit 22 sets. When it has bit 13 set, slot 2 is latched (read at index 2) and bit 21 sets. Writing 0 to a receive status bit clears it. A slot whose tag bit is clear leaves its latched value unchanged.
- R10: Control bit 15 reads the tag bit 15 of the last complete incoming frame. It reads 0 while the link is stopped.
- R11: Only one command is held at a time. A new command address write replaces an unsent command. A command is sent in exactly one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 3 | Register index |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data for `host_addr` (combinational) |
| bit_clk | input | 1 | Serial bit clock from the codec |
| sdata_in | input | 1 | Serial data from the codec |
| sdata_out | output | 1 | Serial data to the codec |
| sync | output | 1 | Frame sync to the codec |
| codec_rst_n | output | 1 | Active-low codec reset |

## Verification
The assertions check on every clock that the link stays silent while the codec is held in reset and that serial output moves only on a recovered bit-clock rising edge. They also check that both sticky flag groups hold until software writes a zero, and that handing a command to a frame empties the single command holder. Frame layout, the exact slot contents of write and read commands, the sent-flag timing inside a frame, the masking by the slot-enable bit, the replacement of an unsent command, status capture and codec-ready tracking all need full frames exchanged with a modelled codec. Only the bench scenarios show these.

// File: rtl/acl_pkg.sv
package acl_pkg;
  localparam int TAG_W      = 16;
  localparam int SLOT_W     = 20;
  localparam int N_SLOTS    = 12;
  localparam int FRAME_BITS = TAG_W + N_SLOTS * SLOT_W;
  localparam int CMD_BITS   = TAG_W + 2 * SLOT_W;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int REG_AW     = 3;
  localparam int DATA_W     = 32;
  localparam int IDX_W      = 7;
  localparam int IDX_LSB    = 12;
  localparam int VAL_W      = 16;
  localparam int VAL_LSB    = 4;

  localparam logic [REG_AW-1:0] RA_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] RA_CADDR = 3'd1;
  localparam logic [REG_AW-1:0] RA_CDATA = 3'd2;
  localparam logic [REG_AW-1:0] RA_TXST  = 3'd3;
  localparam logic [REG_AW-1:0] RA_RXST  = 3'd4;
  localparam logic [REG_AW-1:0] RA_SLOTEN = 3'd5;

  localparam int CB_READY = 15;
  localparam int CB_COLD  = 11;
  localparam int CB_WARM  = 10;
  localparam int CB_START = 5;
  localparam int TB_ASENT = 31;
  localparam int TB_DSENT = 30;
  localparam int RB_ARDY  = 22;
  localparam int RB_DRDY  = 21;
  localparam int SB_EN    = 0;
  localparam int CA_RD    = 19;

  localparam int TAG_VALID = 15;
  localparam int TAG_S1    = 14;
  localparam int TAG_S2    = 13;
endpackage

// File: rtl/acl_bclk_edge.sv
module acl_bclk_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], bclk};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/acl_regs.sv
module acl_regs
  import acl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [REG_AW-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              take,
  input  logic              addr_sent,
  input  logic              data_sent,
  input  logic              cap_a,
  input  logic              cap_d,
  input  logic [SLOT_W-1:0] st_a_in,
  input  logic [SLOT_W-1:0] st_d_in,
  input  logic              rdy_upd,
  input  logic              rdy_val,
  output logic              cold,
  output logic              warm,
  output logic              run,
  output logic              slot_en,
  output logic              pending,
  output logic [SLOT_W-1:0] cmd_a,
  output logic [SLOT_W-1:0] cmd_d,
  output logic              txst_a,
  output logic              txst_d,
  output logic              rxst_a,
  output logic              rxst_d
);
  logic cold_q, cold_d, warm_q, warm_d, start_q, start_d, en_q, en_d;
  logic pend_q, pend_d, rdy_q, rdy_d;
  logic txa_q, txa_d, txd_q, txd_d, rxa_q, rxa_d, rxd_q, rxd_d;
  logic [SLOT_W-1:0] ca_q, ca_d, cd_q, cd_d, sa_q, sa_d, sd_q, sd_d;
  logic w_ctrl, w_ca, w_cd, w_tx, w_rx, w_en;

  always_comb begin
    w_ctrl = host_wr && (host_addr == RA_CTRL);
    w_ca   = host_wr && (host_addr == RA_CADDR);
    w_cd   = host_wr && (host_addr == RA_CDATA);
    w_tx   = host_wr && (host_addr == RA_TXST);
    w_rx   = host_wr && (host_addr == RA_RXST);
    w_en   = host_wr && (host_addr == RA_SLOTEN);

    cold_d  = w_ctrl ? host_wdata[CB_COLD]  : cold_q;
    warm_d  = w_ctrl ? host_wdata[CB_WARM]  : warm_q;
    start_d = w_ctrl ? host_wdata[CB_START] : start_q;
    en_d    = w_en   ? host_wdata[SB_EN]    : en_q;

    ca_d = ca_q;
    if (w_ca) begin
      ca_d = '0;
      ca_d[CA_RD] = host_wdata[CA_RD];
      ca_d[IDX_LSB +: IDX_W] = host_wdata[IDX_LSB +: IDX_W];
    end
    cd_d = cd_q;
    if (w_cd) begin
      cd_d = '0;
      cd_d[VAL_LSB +: VAL_W] = host_wdata[VAL_LSB +: VAL_W];
    end
    // a host write of a new command wins over a hand-off in the same cycle
    pend_d = w_ca ? 1'b1 : (take ? 1'b0 : pend_q);

    txa_d = ((w_tx ? host_wdata[TB_ASENT] : 1'b1) & txa_q) | addr_sent;
    txd_d = ((w_tx ? host_wdata[TB_DSENT] : 1'b1) & txd_q) | data_sent;
    rxa_d = ((w_rx ? host_wdata[RB_ARDY]  : 1'b1) & rxa_q) | cap_a;
    rxd_d = ((w_rx ? host_wdata[RB_DRDY]  : 1'b1) & rxd_q) | cap_d;
    sa_d  = cap_a ? st_a_in : sa_q;
    sd_d  = cap_d ? st_d_in : sd_q;

    rdy_d = !run ? 1'b0 : (rdy_upd ? rdy_val : rdy_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cold_q <= 1'b0; warm_q <= 1'b0; start_q <= 1'b0; en_q <= 1'b0;
      pend_q <= 1'b0; rdy_q <= 1'b0;
      txa_q <= 1'b0; txd_q <= 1'b0; rxa_q <= 1'b0; rxd_q <= 1'b0;
      ca_q <= '0; cd_q <= '0; sa_q <= '0; sd_q <= '0;
    end else begin
      cold_q <= cold_d; warm_q <= warm_d; start_q <= start_d; en_q <= en_d;
      pend_q <= pend_d; rdy_q <= rdy_d;
      txa_q <= txa_d; txd_q <= txd_d; rxa_q <= rxa_d; rxd_q <= rxd_d;
      ca_q <= ca_d; cd_q <= cd_d; sa_q <= sa_d; sd_q <= sd_d;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      RA_CTRL: begin
        host_rdata[CB_READY] = rdy_q;
        host_rdata[CB_COLD]  = cold_q;
        host_rdata[CB_WARM]  = warm_q;
        host_rdata[CB_START] = start_q;
      end
      RA_CADDR:  host_rdata[SLOT_W-1:0] = sa_q;
      RA_CDATA:  host_rdata[SLOT_W-1:0] = sd_q;
      RA_TXST: begin
        host_rdata[TB_ASENT] = txa_q;
        host_rdata[TB_DSENT] = txd_q;
      end
      RA_RXST: begin
        host_rdata[RB_ARDY] = rxa_q;
        host_rdata[RB_DRDY] = rxd_q;
      end
      RA_SLOTEN: host_rdata[SB_EN] = en_q;
      default:   host_rdata = '0;
    endcase
  end

  assign cold    = cold_q;
  assign warm    = warm_q;
  assign run     = start_q & ~cold_q;
  assign slot_en = en_q;
  assign pending = pend_q;
  assign cmd_a   = ca_q;
  assign cmd_d   = cd_q;
  assign txst_a  = txa_q;
  assign txst_d  = txd_q;
  assign rxst_a  = rxa_q;
  assign rxst_d  = rxd_q;
endmodule

// File: rtl/acl_tx.sv
module acl_tx
  import acl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              run,
  input  logic              slot_en,
  input  logic              pending,
  input  logic [SLOT_W-1:0] cmd_a,
  input  logic [SLOT_W-1:0] cmd_d,
  output logic [POS_W-1:0]  pos,
  output logic              sd_out,
  output logic              sync_out,
  output logic              take,
  output logic              addr_sent,
  output logic              data_sent
);
  localparam logic [POS_W-1:0] LAST  = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] A_END = POS_W'(TAG_W + SLOT_W - 1);
  localparam logic [POS_W-1:0] D_END = POS_W'(CMD_BITS - 1);

  logic [POS_W-1:0]    pos_q, pos_d;
  logic [CMD_BITS-1:0] sh_q, sh_d, frame;
  logic [TAG_W-1:0]    tag;
  logic sd_q, sd_d, sy_q, sy_d, hc_q, hc_d, hw_q, hw_d;
  logic send, is_wr;

  always_comb begin
    send  = slot_en & pending;
    is_wr = send & ~cmd_a[CA_RD];
    tag = '0;
    tag[TAG_VALID] = 1'b1;
    tag[TAG_S1]    = send;
    tag[TAG_S2]    = is_wr;
    frame = {tag, {SLOT_W{send}} & cmd_a, {SLOT_W{is_wr}} & cmd_d};

    pos_d = pos_q; sh_d = sh_q; sd_d = sd_q; sy_d = sy_q;
    hc_d = hc_q; hw_d = hw_q;
    take = 1'b0; addr_sent = 1'b0; data_sent = 1'b0;

    if (!run) begin
      pos_d = LAST; sh_d = '0; sd_d = 1'b0; sy_d = 1'b0;
      hc_d = 1'b0; hw_d = 1'b0;
    end else if (rise) begin
      if (pos_q == LAST) begin
        pos_d = '0;
        sd_d  = frame[CMD_BITS-1];
        sh_d  = {frame[CMD_BITS-2:0], 1'b0};
        sy_d  = 1'b1;
        hc_d  = send;
        hw_d  = is_wr;
        take  = send;
      end else begin
        pos_d = pos_q + 1'b1;
        sd_d  = sh_q[CMD_BITS-1];
        sh_d  = {sh_q[CMD_BITS-2:0], 1'b0};
        sy_d  = (int'(pos_q) + 1) < TAG_W;
        addr_sent = hc_q && (pos_q == A_END);
        data_sent = hw_q && (pos_q == D_END);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= LAST; sh_q <= '0; sd_q <= 1'b0; sy_q <= 1'b0;
      hc_q <= 1'b0; hw_q <= 1'b0;
    end else begin
      pos_q <= pos_d; sh_q <= sh_d; sd_q <= sd_d; sy_q <= sy_d;
      hc_q <= hc_d; hw_q <= hw_d;
    end
  end

  assign pos      = pos_q;
  assign sd_out   = sd_q;
  assign sync_out = sy_q;
endmodule

// File: rtl/acl_rx.sv
module acl_rx
  import acl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              run,
  input  logic [POS_W-1:0]  pos,
  input  logic              sdata_in,
  output logic              cap_a,
  output logic              cap_d,
  output logic [SLOT_W-1:0] st_a,
  output logic [SLOT_W-1:0] st_d,
  output logic              rdy_upd,
  output logic              rdy_val
);
  localparam logic [POS_W-1:0] W_END = POS_W'(CMD_BITS - 1);

  logic [CMD_BITS-1:0] sh_q, sh_d, word;
  logic smp, done;

  always_comb begin
    smp  = fall && run && (int'(pos) < CMD_BITS);
    word = {sh_q[CMD_BITS-2:0], sdata_in};
    sh_d = smp ? word : sh_q;
    done = fall && run && (pos == W_END);
    rdy_upd = done;
    rdy_val = word[CMD_BITS-1-(TAG_W-1-TAG_VALID)];
    cap_a   = done & word[CMD_BITS-1-(TAG_W-1-TAG_S1)];
    cap_d   = done & word[CMD_BITS-1-(TAG_W-1-TAG_S2)];
    st_a    = word[2*SLOT_W-1:SLOT_W];
    st_d    = word[SLOT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end
endmodule

// File: rtl/aclink_cmd_engine.sv
module aclink_cmd_engine
  import acl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              host_wr,
  input  logic [REG_AW-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              bit_clk,
  input  logic              sdata_in,
  output logic              sdata_out,
  output logic              sync,
  output logic              codec_rst_n
);
  logic [1:0] rs_q;
  logic rst_n;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  logic rise, fall, take, addr_sent, data_sent, cap_a, cap_d, rdy_upd, rdy_val;
  logic cold, warm, run, slot_en, pending, txst_a, txst_d, rxst_a, rxst_d, tx_sync;
  logic [SLOT_W-1:0] cmd_a, cmd_d, st_a, st_d;
  logic [POS_W-1:0]  pos;

  acl_bclk_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .bclk(bit_clk), .rise(rise), .fall(fall)
  );

  acl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .take(take), .addr_sent(addr_sent), .data_sent(data_sent),
    .cap_a(cap_a), .cap_d(cap_d), .st_a_in(st_a), .st_d_in(st_d),
    .rdy_upd(rdy_upd), .rdy_val(rdy_val),
    .cold(cold), .warm(warm), .run(run), .slot_en(slot_en), .pending(pending),
    .cmd_a(cmd_a), .cmd_d(cmd_d), .txst_a(txst_a), .txst_d(txst_d),
    .rxst_a(rxst_a), .rxst_d(rxst_d)
  );

  acl_tx u_tx (
    .clk(clk), .rst_n(rst_n), .rise(rise), .run(run), .slot_en(slot_en),
    .pending(pending), .cmd_a(cmd_a), .cmd_d(cmd_d), .pos(pos),
    .sd_out(sdata_out), .sync_out(tx_sync), .take(take),
    .addr_sent(addr_sent), .data_sent(data_sent)
  );

  acl_rx u_rx (
    .clk(clk), .rst_n(rst_n), .fall(fall), .run(run), .pos(pos),
    .sdata_in(sdata_in), .cap_a(cap_a), .cap_d(cap_d), .st_a(st_a),
    .st_d(st_d), .rdy_upd(rdy_upd), .rdy_val(rdy_val)
  );

  // wake-up sync only while no frames run and the codec is out of reset
  assign sync        = tx_sync | (warm & ~run & ~cold);
  assign codec_rst_n = ~cold;
endmodule

// File: rtl/aclink_cmd_engine_chk.sv
module aclink_cmd_engine_chk
  import acl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic [REG_AW-1:0] host_addr,
  input logic [DATA_W-1:0] host_wdata,
  input logic              sdata_out,
  input logic              sync,
  input logic              codec_rst_n,
  input logic              rise,
  input logic              run,
  input logic              take,
  input logic              pending,
  input logic              txst_a,
  input logic              rxst_a,
  input logic              rxst_d
);
  // R2: the link goes quiet one clock after the codec is put in reset
  a_r2_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !codec_rst_n |=> !sdata_out && (codec_rst_n || !sync));

  // R4: serial output only moves on a recovered rising bit-clock edge
  a_r4_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    run && !rise |=> $stable(sdata_out));

  // R8: address-sent flag survives until a zero is written to it
  a_r8_tx_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    txst_a && !(host_wr && host_addr == RA_TXST && !host_wdata[TB_ASENT]) |=> txst_a);

  // R9: receive flags survive until a zero is written to them
  a_r9_rx_addr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rxst_a && !(host_wr && host_addr == RA_RXST && !host_wdata[RB_ARDY]) |=> rxst_a);
  a_r9_rx_data_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rxst_d && !(host_wr && host_addr == RA_RXST && !host_wdata[RB_DRDY]) |=> rxst_d);

  // R11: a command handed to a frame leaves the holder empty
  a_r11_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    take && !(host_wr && host_addr == RA_CADDR) |=> !pending);
endmodule

bind aclink_cmd_engine aclink_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .sdata_out(sdata_out), .sync(sync),
  .codec_rst_n(codec_rst_n), .rise(rise), .run(run), .take(take),
  .pending(pending), .txst_a(txst_a), .rxst_a(rxst_a), .rxst_d(rxst_d)
);

// File: tb/tb_aclink_cmd_engine.sv
`timescale 1ns/1ps
module tb_aclink_cmd_engine;
  logic clk = 1'b0;
  logic bclk = 1'b0;
  logic arst_n;
  logic host_wr;
  logic [2:0] host_addr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic sdata_in, sdata_out, sync, codec_rst_n;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  aclink_cmd_engine dut (
    .clk(clk), .arst_n(arst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .bit_clk(bclk),
    .sdata_in(sdata_in), .sdata_out(sdata_out), .sync(sync),
    .codec_rst_n(codec_rst_n)
  );

  always #2.5 clk = ~clk;
  initial begin
    #5;
    forever #20 bclk = ~bclk;
  end

  // reference model state
  bit m_run = 0, m_cold = 0, m_warm = 0, m_en = 0, m_pend = 0;
  logic [19:0] m_ca = '0, m_cd = '0;
  logic [55:0] mf = '0;
  logic [55:0] rf = '0;
  bit locked = 0;
  int idx = 0;
  int shown = -1;
  bit resp_arm = 0;
  logic [15:0] resp_tag = '0;
  logic [19:0] resp_a = '0, resp_d = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-bit comparison of the link pins against the model
  always @(negedge bclk) begin
    if (arst_n === 1'b1) begin
      chk("R2 codec reset pin", {31'b0, codec_rst_n}, {31'b0, !m_cold});
      if (!m_run) begin
        locked = 0;
        shown = -1;
        chk("R3 idle sync", {31'b0, sync}, {31'b0, m_warm && !m_cold});
        chk("R2 idle data", {31'b0, sdata_out}, 32'd0);
      end else begin
        if (!locked && sync === 1'b1) begin
          locked = 1;
          idx = 0;
        end
        if (locked) begin
          if (idx == 0) begin
            if (m_en && m_pend) begin
              mf = {1'b1, 1'b1, !m_ca[19], 13'b0, m_ca, m_ca[19] ? 20'b0 : m_cd};
              m_pend = 0;
            end else begin
              mf = {16'h8000, 40'b0};
            end
          end
          chk($sformatf("R4 sync bit %0d", idx), {31'b0, sync}, {31'b0, idx < 16});
          chk($sformatf("R5 data bit %0d", idx), {31'b0, sdata_out},
              {31'b0, (idx < 56) ? mf[55-idx] : 1'b0});
          shown = idx;
          idx = (idx + 1) % 256;
        end
      end
    end
  end

  // modelled codec: drives the bit for the next position after each rise
  always @(posedge bclk) begin
    if (locked) begin
      if (idx == 0) begin
        rf = resp_arm ? {resp_tag, resp_a, resp_d} : {16'h8000, 40'b0};
        resp_arm = 0;
      end
      sdata_in = (idx < 56) ? rf[55-idx] : 1'b0;
    end else begin
      sdata_in = 1'b0;
    end
  end

  task automatic hwr(input logic [2:0] a, input logic [31:0] d);
    @(posedge bclk);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    case (a)
      3'd0: begin m_cold = d[11]; m_warm = d[10]; m_run = d[5] && !d[11]; end
      3'd1: begin m_ca = {d[19], d[18:12], 12'b0}; m_pend = 1; end
      3'd2: m_cd = {d[19:4], 4'b0};
      3'd5: m_en = d[0];
      default: ;
    endcase
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hrd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic wait_pos(input int n);
    do begin
      @(negedge bclk);
      #1;
    end while (!(locked && shown == n));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: all requirements, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    arst_n = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0; sdata_in = 1'b0;
    #52;
    arst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    hrd(3'd0, v); chk("R1 control", v, 32'h0);
    hrd(3'd3, v); chk("R1 tx status", v, 32'h0);
    hrd(3'd4, v); chk("R1 rx status", v, 32'h0);
    hrd(3'd5, v); chk("R1 slot enable", v, 32'h0);
    chk("R1 pins", {29'b0, codec_rst_n, sync, sdata_out}, 32'h4);

    // R2 cold reset with start also set: link stays silent
    hwr(3'd0, 32'h0000_0820);
    repeat (6) @(negedge bclk);
    #1 chk("R2 reset pin low", {31'b0, codec_rst_n}, 32'd0);
    hwr(3'd0, 32'h0);

    // R3 wake-up sync while idle
    hwr(3'd0, 32'h0000_0400);
    repeat (4) @(negedge bclk);
    #1 chk("R3 sync high while idle", {31'b0, sync}, 32'd1);
    hwr(3'd0, 32'h0);

    // R4 free-running frames, R10 ready follows codec tag
    hwr(3'd0, 32'h0000_0020);
    wait_pos(0); wait_pos(0); wait_pos(60);
    hrd(3'd0, v); chk("R10 codec ready set", v, 32'h0000_8020);

    // R3 warm bit ignored while running (per-bit model keeps comparing)
    hwr(3'd0, 32'h0000_0420);
    wait_pos(0); wait_pos(100);
    hwr(3'd0, 32'h0000_0020);

    // R7 command held while slot enable clear
    wait_pos(100);
    hwr(3'd2, 32'h000B_EEF0);
    hwr(3'd1, 32'h0002_6000);
    wait_pos(60);
    hrd(3'd3, v); chk("R7 held, nothing sent", v, 32'h0);
    hwr(3'd5, 32'h1);

    // R5 write frame and R8 flag timing
    wait_pos(45);
    hrd(3'd3, v); chk("R8 address flag after slot 1", v, 32'h8000_0000);
    wait_pos(60);
    hrd(3'd3, v); chk("R8 both flags after slot 2", v, 32'hC000_0000);
    hwr(3'd3, 32'h4000_0000);
    hrd(3'd3, v); chk("R8 zero clears, one keeps", v, 32'h4000_0000);
    hwr(3'd3, 32'h0);
    wait_pos(60);
    hrd(3'd3, v); chk("R11 sent only once", v, 32'h0);

    // R6 read command
    hwr(3'd1, 32'h0008_0000 | (32'h7C << 12));
    wait_pos(60);
    hrd(3'd3, v); chk("R6 read sets address flag only", v, 32'h8000_0000);
    hwr(3'd3, 32'h0);

    // R11 replacement of an unsent command
    hwr(3'd2, 32'h0005_5550);
    hwr(3'd1, 32'h0001_1000);
    hwr(3'd1, 32'h0008_0000 | (32'h22 << 12));
    wait_pos(60);
    hrd(3'd3, v); chk("R11 replaced by read", v, 32'h8000_0000);
    hwr(3'd3, 32'h0);

    // R9 status capture
    resp_tag = 16'hE000; resp_a = 20'h7C000; resp_d = 20'h12340; resp_arm = 1;
    wait_pos(0); wait_pos(60);
    hrd(3'd4, v); chk("R9 both ready flags", v, 32'h0060_0000);
    hrd(3'd1, v); chk("R9 status address", v, 32'h0007_C000);
    hrd(3'd2, v); chk("R9 status data", v, 32'h0001_2340);
    hwr(3'd4, 32'h0020_0000);
    hrd(3'd4, v); chk("R9 zero clears address flag", v, 32'h0020_0000);
    hwr(3'd4, 32'h0);
    resp_tag = 16'hC000; resp_a = 20'h05000; resp_d = 20'hAAAA0; resp_arm = 1;
    wait_pos(0); wait_pos(60);
    hrd(3'd4, v); chk("R9 address flag only", v, 32'h0040_0000);
    hrd(3'd1, v); chk("R9 new status address", v, 32'h0000_5000);
    hrd(3'd2, v); chk("R9 data unchanged", v, 32'h0001_2340);

    // R10 codec ready tracks tag bit 15
    resp_tag = 16'h0000; resp_a = '0; resp_d = '0; resp_arm = 1;
    wait_pos(0); wait_pos(60);
    hrd(3'd0, v); chk("R10 codec ready cleared", v, 32'h0000_0020);
    wait_pos(60);
    hrd(3'd0, v); chk("R10 codec ready back", v, 32'h0000_8020);

    // stop the link
    hwr(3'd0, 32'h0);
    repeat (4) @(negedge bclk);
    #1;
    hrd(3'd0, v); chk("R10 ready clears when stopped", v, 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule